// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It expands one tagged scalar instruction into a run of per-element micro-operations. A start pulse captures the vector length, three register base numbers (one destination, two sources) each with its own vector/scalar flag, a predicate mask, a zeroing flag and a fail-first flag. While the loop runs, the block offers one element per cycle on a valid/ready handshake. Each element carries its index, the three register indices and an action: write, write-zero or skip.

A vector operand's register index steps by one per element. A scalar operand's index stays at its base. Masked-out elements still move the indices forward. A scalar destination ends the loop after its first active element. In fail-first mode the execution side returns a test result for each element during that element's handshake. The first active element whose test fails cuts the vector length to that element's index. The execution side must discard that element's write.

When the loop finishes, the block pulses done. This releases the program counter. At the same moment it reports the final vector length, which may have been truncated.

Top module: `vec_elem_seq`

## Requirements
- R1: After an accepted start, element indices are offered in strict order 0,1,2,… with one element per accepted handshake. `done_o` pulses high in the cycle that follows the last accepted element, and `uop_valid_o` is low while `done_o` is high.
- R2: For each operand, the register index is base + element index (modulo 2^REG_W) when its vector flag is set, and equals the base when the flag is clear.
- R3: An element whose effective predicate bit is clear gets action skip (`uop_act_o` = 2'b10) when zeroing is off. It is still offered, and the vector operand indices keep stepping. An element whose bit is set gets action write (2'b00).
- R4: With `pred_en_i` low, the mask is taken as all ones, whatever `pred_mask_i` holds.
- R5: With a scalar destination, the loop ends after the first element with a set predicate bit is accepted. Leading masked elements step only the vector sources. `final_vl_o` equals the supplied VL.
- R6: With `zero_i` high, a masked-out element gets action write-zero (`uop_act_o` = 2'b01) in place of skip.
- R7: With `ffirst_i` high, an element with a set predicate bit that is accepted while `test_fail_i` is high ends the loop, and `final_vl_o` becomes that element's index. The execution side drops that element's write. `test_fail_i` has no effect on masked-out elements.
- R8: VL values from 1 to MAX_VL (64) inclusive are supported, and every index up to MAX_VL-1 is issued.
- R9: A start with VL = 0 issues nothing, and `done_o` pulses in the cycle after the start, with `final_vl_o` = 0.
- R10: A start pulse that arrives while a loop is running (`uop_valid_o` high) is ignored. The running loop keeps its captured operands and length.
- R11: While `uop_valid_o` is high and `uop_ready_i` is low, the offered element (index, registers and action) is held unchanged.
- R12: After reset, `uop_valid_o` and `done_o` are low and `final_vl_o` is 0. `final_vl_o` keeps its value after the done pulse until the next loop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | 7 | Vector length, 0 to 64 |
| dst_reg_i | input | 7 | Destination register base |
| dst_vec_i | input | 1 | Destination is a vector |
| srca_reg_i | input | 7 | First source register base |
| srca_vec_i | input | 1 | First source is a vector |
| srcb_reg_i | input | 7 | Second source register base |
| srcb_vec_i | input | 1 | Second source is a vector |
| pred_en_i | input | 1 | Predicate mask supplied |
| pred_mask_i | input | 64 | Predicate mask, bit i for element i |
| zero_i | input | 1 | Zeroing mode for masked elements |
| ffirst_i | input | 1 | Data-dependent fail-first mode |
| uop_valid_o | output | 1 | Element offered |
| uop_ready_i | input | 1 | Issue side accepts the element |
| uop_idx_o | output | 6 | Element index |
| uop_dst_o | output | 7 | Destination register index |
| uop_srca_o | output | 7 | First source register index |
| uop_srcb_o | output | 7 | Second source register index |
| uop_act_o | output | 2 | 00 write, 01 write zero, 10 skip |
| test_fail_i | input | 1 | Test result of the offered element failed |
| done_o | output | 1 | Loop finished, PC may advance |
| final_vl_o | output | 7 | Resulting vector length |

## Verification
The bench goes after the following corner cases.

- **Scalar destination behind leading masked elements.** A design that stopped on the first element, or that froze the vector sources while skipping, would issue too few elements or wrong source indices.
- **Fail-first failure flagged on a masked element before the real failure.** A design that tested masked elements would truncate VL too early.
- **Failure at element 0.** This must give a length of zero.
- **VL of zero.** A design that issued one element here would show a spurious handshake.
- **Full 64-element loop, under back-pressure and with a register base that wraps.** This exposes off-by-one exits and index overflow.
- **Start re-pulsed mid-loop with different operands.** A design that re-armed would show altered indices or a shortened loop.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

   typedef enum logic [1:0] {
      ACT_WRITE = 2'b00,
      ACT_ZERO  = 2'b01,
      ACT_SKIP  = 2'b10
   } vseq_act_e;

   localparam int unsigned NUM_OPND = 3;
   localparam int unsigned OPND_DST = 0;
   localparam int unsigned OPND_SA  = 1;
   localparam int unsigned OPND_SB  = 2;

endpackage

// File: rtl/vseq_mask_sel.sv
module vseq_mask_sel #(
   parameter int MAX_VL       = 64,
   parameter bit PRED_SUPPORT = 1'b1
) (
   input  logic              pred_en_i,
   input  logic [MAX_VL-1:0] pred_mask_i,
   output logic [MAX_VL-1:0] eff_mask_o
);

   generate
      if (PRED_SUPPORT) begin : g_pred
         assign eff_mask_o = pred_en_i ? pred_mask_i : {MAX_VL{1'b1}};
      end else begin : g_nopred
         logic unused_pred;
         assign unused_pred = pred_en_i ^ (^pred_mask_i);
         assign eff_mask_o  = {MAX_VL{1'b1}};
      end
   endgenerate

endmodule

// File: rtl/vseq_opnd_idx.sv
module vseq_opnd_idx #(
   parameter int REG_W = 7,
   parameter int IDX_W = 6
) (
   input  logic [REG_W-1:0] base_i,
   input  logic             vec_i,
   input  logic [IDX_W-1:0] elem_i,
   output logic [REG_W-1:0] reg_o
);

   logic [REG_W-1:0] offset;

   always_comb begin
      offset = '0;
      if (vec_i) offset = REG_W'(elem_i);
      reg_o = base_i + offset;
   end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
   parameter  int MAX_VL = 64,
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int VL_W   = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VL_W-1:0]  vl_i,
   input  logic             accept_i,
   input  logic             active_i,
   input  logic             dst_vec_i,
   input  logic             ffirst_i,
   input  logic             test_fail_i,
   output logic             running_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o,
   output logic [VL_W-1:0]  final_vl_o
);

   logic             running_q;
   logic [IDX_W-1:0] idx_q;
   logic [VL_W-1:0]  vl_q;
   logic             done_q;
   logic [VL_W-1:0]  fvl_q;

   logic last_elem;
   logic ff_stop;
   logic scalar_stop;

   assign last_elem   = ({1'b0, idx_q} + VL_W'(1)) == vl_q;
   assign ff_stop     = ffirst_i && active_i && test_fail_i;
   assign scalar_stop = !dst_vec_i && active_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         idx_q     <= '0;
         vl_q      <= '0;
         done_q    <= 1'b0;
         fvl_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!running_q) begin
            if (start_i) begin
               idx_q <= '0;
               vl_q  <= vl_i;
               if (vl_i == '0) begin
                  done_q <= 1'b1;
                  fvl_q  <= '0;
               end else begin
                  running_q <= 1'b1;
               end
            end
         end else if (accept_i) begin
            if (ff_stop) begin
               running_q <= 1'b0;
               done_q    <= 1'b1;
               fvl_q     <= {1'b0, idx_q};
            end else if (scalar_stop || last_elem) begin
               running_q <= 1'b0;
               done_q    <= 1'b1;
               fvl_q     <= vl_q;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign running_o  = running_q;
   assign idx_o      = idx_q;
   assign done_o     = done_q;
   assign final_vl_o = fvl_q;

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vseq_pkg::*;
#(
   parameter  int MAX_VL       = 64,
   parameter  int REG_W        = 7,
   parameter  bit PRED_SUPPORT = 1'b1,
   localparam int IDX_W        = $clog2(MAX_VL),
   localparam int VL_W         = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [REG_W-1:0]  dst_reg_i,
   input  logic              dst_vec_i,
   input  logic [REG_W-1:0]  srca_reg_i,
   input  logic              srca_vec_i,
   input  logic [REG_W-1:0]  srcb_reg_i,
   input  logic              srcb_vec_i,
   input  logic              pred_en_i,
   input  logic [MAX_VL-1:0] pred_mask_i,
   input  logic              zero_i,
   input  logic              ffirst_i,
   output logic              uop_valid_o,
   input  logic              uop_ready_i,
   output logic [IDX_W-1:0]  uop_idx_o,
   output logic [REG_W-1:0]  uop_dst_o,
   output logic [REG_W-1:0]  uop_srca_o,
   output logic [REG_W-1:0]  uop_srcb_o,
   output logic [1:0]        uop_act_o,
   input  logic              test_fail_i,
   output logic              done_o,
   output logic [VL_W-1:0]   final_vl_o
);

   generate
      if (MAX_VL < 2 || MAX_VL > 64) begin : g_bad_vl
         $error("vec_elem_seq: MAX_VL must lie in 2..64");
      end
      if (REG_W < 1 || REG_W > 16) begin : g_bad_reg
         $error("vec_elem_seq: REG_W must lie in 1..16");
      end
   endgenerate

   logic                 running;
   logic                 start_ok;
   logic [MAX_VL-1:0]    eff_mask;
   logic [MAX_VL-1:0]    mask_q;
   logic [NUM_OPND-1:0]  vec_q;
   logic [REG_W-1:0]     base_q  [NUM_OPND];
   logic [REG_W-1:0]     opnd_reg[NUM_OPND];
   logic                 zero_q;
   logic                 ff_q;
   logic                 dvec_q;
   logic                 active;
   logic                 accept;
   vseq_act_e            act;

   assign start_ok = start_i && !running;
   assign dvec_q   = vec_q[OPND_DST];

   vseq_mask_sel #(
      .MAX_VL       (MAX_VL),
      .PRED_SUPPORT (PRED_SUPPORT)
   ) u_mask (
      .pred_en_i   (pred_en_i),
      .pred_mask_i (pred_mask_i),
      .eff_mask_o  (eff_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         vec_q  <= '0;
         zero_q <= 1'b0;
         ff_q   <= 1'b0;
         for (int k = 0; k < NUM_OPND; k++) base_q[k] <= '0;
      end else if (start_ok) begin
         mask_q         <= eff_mask;
         vec_q          <= {srcb_vec_i, srca_vec_i, dst_vec_i};
         zero_q         <= zero_i;
         ff_q           <= ffirst_i;
         base_q[OPND_DST] <= dst_reg_i;
         base_q[OPND_SA]  <= srca_reg_i;
         base_q[OPND_SB]  <= srcb_reg_i;
      end
   end

   assign active = mask_q[uop_idx_o];
   assign accept = running && uop_ready_i;

   vseq_ctrl #(
      .MAX_VL (MAX_VL)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vl_i        (vl_i),
      .accept_i    (accept),
      .active_i    (active),
      .dst_vec_i   (dvec_q),
      .ffirst_i    (ff_q),
      .test_fail_i (test_fail_i),
      .running_o   (running),
      .idx_o       (uop_idx_o),
      .done_o      (done_o),
      .final_vl_o  (final_vl_o)
   );

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         vseq_opnd_idx #(
            .REG_W (REG_W),
            .IDX_W (IDX_W)
         ) u_idx (
            .base_i (base_q[g]),
            .vec_i  (vec_q[g]),
            .elem_i (uop_idx_o),
            .reg_o  (opnd_reg[g])
         );
      end
   endgenerate

   always_comb begin
      if (active)      act = ACT_WRITE;
      else if (zero_q) act = ACT_ZERO;
      else             act = ACT_SKIP;
   end

   assign uop_valid_o = running;
   assign uop_dst_o   = opnd_reg[OPND_DST];
   assign uop_srca_o  = opnd_reg[OPND_SA];
   assign uop_srcb_o  = opnd_reg[OPND_SB];
   assign uop_act_o   = act;

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
   parameter  int MAX_VL = 64,
   parameter  int REG_W  = 7,
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int VL_W   = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [VL_W-1:0]  vl_i,
   input logic             uop_valid_o,
   input logic             uop_ready_i,
   input logic [IDX_W-1:0] uop_idx_o,
   input logic [REG_W-1:0] uop_dst_o,
   input logic [REG_W-1:0] uop_srca_o,
   input logic [1:0]       uop_act_o,
   input logic             done_o,
   input logic [VL_W-1:0]  final_vl_o,
   input logic             dvec_q
);

   assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_o && uop_ready_i) |=>
         (done_o || (uop_valid_o && uop_idx_o == $past(uop_idx_o) + 1'b1)));

   assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !uop_valid_o);

   assert_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_o && uop_ready_i) |=>
         (!uop_valid_o || uop_srca_o == $past(uop_srca_o)
          || uop_srca_o == $past(uop_srca_o) + 1'b1));

   assert_scalar_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_o && uop_ready_i && !dvec_q && uop_act_o == 2'b00) |=> done_o);

   assert_act_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid_o |-> (uop_act_o != 2'b11));

   assert_vl_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (final_vl_o <= VL_W'(MAX_VL)));

   assert_zero_vl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !uop_valid_o && vl_i == '0) |=> (done_o && !uop_valid_o));

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && uop_valid_o && !uop_ready_i) |=> uop_valid_o);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_o && !uop_ready_i) |=>
         (uop_valid_o && $stable(uop_idx_o) && $stable(uop_dst_o)
          && $stable(uop_srca_o) && $stable(uop_act_o)));

endmodule

bind vec_elem_seq vseq_chk #(
   .MAX_VL (MAX_VL),
   .REG_W  (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .vl_i        (vl_i),
   .uop_valid_o (uop_valid_o),
   .uop_ready_i (uop_ready_i),
   .uop_idx_o   (uop_idx_o),
   .uop_dst_o   (uop_dst_o),
   .uop_srca_o  (uop_srca_o),
   .uop_act_o   (uop_act_o),
   .done_o      (done_o),
   .final_vl_o  (final_vl_o),
   .dvec_q      (dvec_q)
);

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_VL     = 64;
   localparam int REG_W      = 7;
   localparam int IDX_W      = 6;
   localparam int VL_W       = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [VL_W-1:0]   vl_i = '0;
   logic [REG_W-1:0]  dst_reg_i = '0;
   logic              dst_vec_i = 1'b0;
   logic [REG_W-1:0]  srca_reg_i = '0;
   logic              srca_vec_i = 1'b0;
   logic [REG_W-1:0]  srcb_reg_i = '0;
   logic              srcb_vec_i = 1'b0;
   logic              pred_en_i = 1'b0;
   logic [MAX_VL-1:0] pred_mask_i = '0;
   logic              zero_i = 1'b0;
   logic              ffirst_i = 1'b0;
   logic              uop_valid_o;
   logic              uop_ready_i = 1'b0;
   logic [IDX_W-1:0]  uop_idx_o;
   logic [REG_W-1:0]  uop_dst_o;
   logic [REG_W-1:0]  uop_srca_o;
   logic [REG_W-1:0]  uop_srcb_o;
   logic [1:0]        uop_act_o;
   logic              test_fail_i = 1'b0;
   logic              done_o;
   logic [VL_W-1:0]   final_vl_o;

   int n_chk  = 0;
   int n_fail = 0;

   int e_idx [64];
   int e_dst [64];
   int e_sa  [64];
   int e_sb  [64];
   int e_act [64];
   int e_n;
   int e_fvl;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_elem_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vl_i        (vl_i),
      .dst_reg_i   (dst_reg_i),
      .dst_vec_i   (dst_vec_i),
      .srca_reg_i  (srca_reg_i),
      .srca_vec_i  (srca_vec_i),
      .srcb_reg_i  (srcb_reg_i),
      .srcb_vec_i  (srcb_vec_i),
      .pred_en_i   (pred_en_i),
      .pred_mask_i (pred_mask_i),
      .zero_i      (zero_i),
      .ffirst_i    (ffirst_i),
      .uop_valid_o (uop_valid_o),
      .uop_ready_i (uop_ready_i),
      .uop_idx_o   (uop_idx_o),
      .uop_dst_o   (uop_dst_o),
      .uop_srca_o  (uop_srca_o),
      .uop_srcb_o  (uop_srcb_o),
      .uop_act_o   (uop_act_o),
      .test_fail_i (test_fail_i),
      .done_o      (done_o),
      .final_vl_o  (final_vl_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Expected element list built from the requirements (R2..R7)
   task automatic build_model(input int vl, input int d, input int a, input int b,
                              input bit dv, input bit av, input bit bv,
                              input bit pen, input logic [63:0] mask,
                              input bit zr, input bit ff, input logic [63:0] fails);
      e_n   = 0;
      e_fvl = vl;
      for (int i = 0; i < vl; i++) begin
         bit on;
         on = !pen || mask[i];
         e_idx[e_n] = i;
         e_dst[e_n] = (d + (dv ? i : 0)) % 128;
         e_sa[e_n]  = (a + (av ? i : 0)) % 128;
         e_sb[e_n]  = (b + (bv ? i : 0)) % 128;
         e_act[e_n] = on ? 0 : (zr ? 1 : 2);
         e_n++;
         if (on && ff && fails[i]) begin
            e_fvl = i;
            break;
         end
         if (on && !dv) break;
      end
   endtask

   task automatic run_case(input string req, input int vl,
                           input int d, input int a, input int b,
                           input bit dv, input bit av, input bit bv,
                           input bit pen, input logic [63:0] mask,
                           input bit zr, input bit ff, input logic [63:0] fails,
                           input bit stall, input bit probe);
      int  got;
      bit  prev_last;
      bit  seen_done;
      build_model(vl, d, a, b, dv, av, bv, pen, mask, zr, ff, fails);
      @(negedge clk);
      vl_i        = VL_W'(vl);
      dst_reg_i   = REG_W'(d);
      srca_reg_i  = REG_W'(a);
      srcb_reg_i  = REG_W'(b);
      dst_vec_i   = dv;
      srca_vec_i  = av;
      srcb_vec_i  = bv;
      pred_en_i   = pen;
      pred_mask_i = mask;
      zero_i      = zr;
      ffirst_i    = ff;
      start_i     = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
      got       = 0;
      prev_last = (e_n == 0);
      seen_done = 1'b0;
      for (int cyc = 0; cyc < 2000 && !seen_done; cyc++) begin
         bit acc;
         uop_ready_i = stall ? ((cyc % 3) != 2) : 1'b1;
         test_fail_i = uop_valid_o ? fails[uop_idx_o] : 1'b0;
         if (probe && cyc == 1) begin
            // R10: new operands and length offered mid-loop
            start_i   = 1'b1;
            vl_i      = 7'd2;
            dst_reg_i = REG_W'(d + 9);
         end else begin
            start_i = 1'b0;
         end
         #1;
         acc = uop_valid_o && uop_ready_i;
         if (done_o) begin
            seen_done = 1'b1;
            check(prev_last, "R1", "done one cycle after last element", 0, 1);
            check(got == e_n, req, "element count", got, e_n);
            check(final_vl_o == VL_W'(e_fvl), req, "final VL", final_vl_o, e_fvl);
            check(!uop_valid_o, "R1", "valid low with done", uop_valid_o, 0);
         end else if (acc) begin
            if (got < e_n) begin
               check(uop_idx_o == IDX_W'(e_idx[got]), req, "element index", uop_idx_o, e_idx[got]);
               check(uop_dst_o == REG_W'(e_dst[got]), req, "dest register", uop_dst_o, e_dst[got]);
               check(uop_srca_o == REG_W'(e_sa[got]), req, "src a register", uop_srca_o, e_sa[got]);
               check(uop_srcb_o == REG_W'(e_sb[got]), req, "src b register", uop_srcb_o, e_sb[got]);
               check(uop_act_o == 2'(e_act[got]), req, "action", uop_act_o, e_act[got]);
            end else begin
               check(1'b0, req, "element beyond expected count", got, e_n);
            end
            got++;
         end
         prev_last = acc && (got == e_n);
         @(negedge clk);
      end
      start_i     = 1'b0;
      uop_ready_i = 1'b0;
      test_fail_i = 1'b0;
      check(seen_done, req, "done observed", seen_done, 1);
      #1;
      // R12: done is a single pulse and the result length is held
      check(!done_o, "R12", "done pulse width", done_o, 0);
      check(final_vl_o == VL_W'(e_fvl), "R12", "final VL held", final_vl_o, e_fvl);
   endtask

   task automatic test_reset();
      #1;
      check(!uop_valid_o, "R12", "valid after reset", uop_valid_o, 0);
      check(!done_o, "R12", "done after reset", done_o, 0);
      check(final_vl_o == '0, "R12", "final VL after reset", final_vl_o, 0);
   endtask

   task automatic test_all_vector();   // R1, R2
      run_case("R1", 5, 10, 20, 30, 1, 1, 1, 0, 64'h0, 0, 0, 64'h0, 0, 0);
   endtask

   task automatic test_mixed_wrap();   // R2 scalar source, wrapping base
      run_case("R2", 6, 4, 50, 126, 1, 0, 1, 0, 64'h0, 0, 0, 64'h0, 0, 0);
   endtask

   task automatic test_masked_skip();  // R3 with back-pressure (R11)
      run_case("R3", 8, 40, 60, 80, 1, 1, 1, 1, 64'hB2, 0, 0, 64'h0, 1, 0);
   endtask

   task automatic test_no_pred();      // R4: mask ignored when pred_en low
      run_case("R4", 4, 1, 2, 3, 1, 1, 1, 0, 64'h0, 0, 0, 64'h0, 0, 0);
   endtask

   task automatic test_scalar_dst();   // R5
      run_case("R5", 8, 7, 16, 32, 0, 1, 1, 1, 64'h28, 0, 0, 64'h0, 0, 0);
      run_case("R5", 3, 7, 16, 32, 0, 1, 0, 1, 64'h0, 0, 0, 64'h0, 0, 0);
   endtask

   task automatic test_zeroing();      // R6
      run_case("R6", 4, 90, 91, 92, 1, 1, 1, 1, 64'h5, 1, 0, 64'h0, 0, 0);
   endtask

   task automatic test_fail_first();   // R7
      run_case("R7", 8, 12, 24, 36, 1, 1, 1, 1, 64'hF7, 0, 1, 64'h28, 1, 0);
      run_case("R7", 6, 12, 24, 36, 1, 1, 1, 0, 64'h0, 0, 1, 64'h1, 0, 0);
   endtask

   task automatic test_max_vl();       // R8
      run_case("R8", 64, 0, 64, 100, 1, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64'h0, 1, 0);
   endtask

   task automatic test_zero_vl();      // R9
      run_case("R9", 0, 5, 5, 5, 1, 1, 1, 0, 64'h0, 0, 0, 64'h0, 0, 0);
   endtask

   task automatic test_start_ignored(); // R10
      run_case("R10", 8, 20, 30, 40, 1, 1, 0, 0, 64'h0, 0, 0, 64'h0, 1, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_all_vector();
      test_mixed_wrap();
      test_masked_skip();
      test_no_pred();
      test_scalar_dst();
      test_zeroing();
      test_fail_first();
      test_max_vl();
      test_zero_vl();
      test_start_ignored();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule